// File: doc/BRIEF.md
# Packet-Aligned Receive Word Packer

This block sits between a display serial link receiver and a receive FIFO. The receiver hands it one byte per clock, qualified by a valid strobe. The block packs these bytes into 32-bit words and raises a write strobe for each finished word. It follows packet framing so that the FIFO contents stay word-aligned per packet. Every packet opens a fresh word, and its first header byte sits in the lowest byte lane.

Each packet begins with four header bytes, the last of which is the ECC byte. These four bytes always form one word. Bit 3 of the first header byte marks the packet as long or short. A short packet is complete after its header word. For a long packet, header bytes 1 and 2 give a 16-bit payload byte count. The payload is packed into words, and the last partial word is filled with a pad byte. The two checksum bytes that follow the payload are consumed and never written out.

Top module: `pkt_word_packer`

## Requirements
- R1: Accepted bytes fill a word from lane 0 upward, with byte k of a run placed in bits [8k+7:8k]. A byte that lands in lane 3 completes the word.
- R2: The first byte of every packet lands in lane 0 (bits 7:0) of a new word, whatever the previous packet's length was.
- R3: The four header bytes form exactly one word {ECC, hdr2, hdr1, hdr0}. If bit 3 of hdr0 is 0, the packet is short, and the next accepted byte is the next packet's hdr0.
- R4: If bit 3 of hdr0 is 1, the payload length in bytes is {hdr2, hdr1}. When the length is not a multiple of four, the last payload word has its unused upper lanes set to the pad byte 8'h00. When the length is a multiple of four, no extra pad word is written.
- R5: The two bytes after a long packet's payload are consumed and never written. A length of zero goes straight from the header word to these two bytes, and the byte after them is the next hdr0.
- R6: A byte presented while in_valid is low is ignored: it is not stored, does not advance any count, and causes no write.
- R7: While rst is high, word_wr is low in the following cycle. After reset, the next accepted byte is treated as hdr0 in lane 0.
- R8: word_wr is high for exactly one cycle per finished word, in the cycle after the completing byte is accepted, with word_out holding that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte qualifier |
| in_byte | input | 8 | Incoming byte |
| word_out | output | 32 | Finished word, lane 0 in bits 7:0 |
| word_wr | output | 1 | One-cycle write strobe for word_out |

## Verification
Two functions can fall in the same cycle: the natural completion of a word when a byte lands in lane 3, and the pad-and-flush at the end of a payload. The bench provokes this by sweeping payload lengths 0 through 13, plus lengths of 256 and above, so that the end of the payload hits every lane, including lane 3 for lengths that are multiples of four. When the two coincide, the bench expects a single strobe with no trailing all-pad word. The next header must still start in lane 0. Idle gaps with junk bytes are mixed into the same sweep, so a gap may fall just before a completing byte.

// File: rtl/pkw_pkg.sv
package pkw_pkg;

   typedef enum logic [1:0] {
      ST_HDR = 2'd0,
      ST_PAY = 2'd1,
      ST_CRC = 2'd2
   } pkw_state_e;

endpackage

// File: rtl/pkw_pkt_fsm.sv
module pkw_pkt_fsm
   import pkw_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int HDR_BYTES = 4,
   parameter int CRC_BYTES = 2,
   parameter int LONG_BIT  = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              take,
   output logic              close,
   output logic              hdr_first,
   output pkw_state_e        state
);
   localparam int CNT_W  = 2 * BYTE_W;
   localparam int HIDX_W = $clog2(HDR_BYTES);
   localparam int CRC_W  = $clog2(CRC_BYTES + 1);

   pkw_state_e        st_q;
   logic [HIDX_W-1:0] hidx_q;
   logic [CNT_W-1:0]  rem_q;
   logic [CNT_W-1:0]  len_q;
   logic              long_q;
   logic [CRC_W-1:0]  crc_q;

   logic hdr_last;
   logic pay_last;

   assign hdr_last  = (hidx_q == HIDX_W'(HDR_BYTES - 1));
   assign pay_last  = (rem_q == CNT_W'(1));
   assign take      = in_valid && (st_q != ST_CRC);
   assign close     = in_valid && (((st_q == ST_HDR) && hdr_last) ||
                                   ((st_q == ST_PAY) && pay_last));
   assign hdr_first = (st_q == ST_HDR) && (hidx_q == '0);
   assign state     = st_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_HDR;
         hidx_q <= '0;
         rem_q  <= '0;
         len_q  <= '0;
         long_q <= 1'b0;
         crc_q  <= '0;
      end else if (in_valid) begin
         unique case (st_q)
            ST_HDR: begin
               if (hidx_q == HIDX_W'(0)) long_q <= in_byte[LONG_BIT];
               if (hidx_q == HIDX_W'(1)) len_q[BYTE_W-1:0] <= in_byte;
               if (hidx_q == HIDX_W'(2)) len_q[CNT_W-1:BYTE_W] <= in_byte;
               if (hdr_last) begin
                  hidx_q <= '0;
                  if (!long_q) begin
                     st_q <= ST_HDR;
                  end else if (len_q == '0) begin
                     st_q  <= ST_CRC;
                     crc_q <= CRC_W'(CRC_BYTES - 1);
                  end else begin
                     st_q  <= ST_PAY;
                     rem_q <= len_q;
                  end
               end else begin
                  hidx_q <= hidx_q + HIDX_W'(1);
               end
            end
            ST_PAY: begin
               rem_q <= rem_q - CNT_W'(1);
               if (pay_last) begin
                  st_q  <= ST_CRC;
                  crc_q <= CRC_W'(CRC_BYTES - 1);
               end
            end
            ST_CRC: begin
               if (crc_q == '0) st_q <= ST_HDR;
               else             crc_q <= crc_q - CRC_W'(1);
            end
            default: st_q <= ST_HDR;
         endcase
      end
   end

endmodule

// File: rtl/pkw_lane_asm.sv
module pkw_lane_asm #(
   parameter int                BYTE_W = 8,
   parameter int                LANES  = 4,
   parameter logic [BYTE_W-1:0] DUMMY  = '0
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [BYTE_W-1:0]         in_byte,
   input  logic                      take,
   input  logic                      close,
   output logic [BYTE_W*LANES-1:0]   word_out,
   output logic                      word_wr,
   output logic [$clog2(LANES)-1:0]  lane_idx
);
   localparam int LIDX_W = $clog2(LANES);
   localparam int WORD_W = BYTE_W * LANES;

   logic [LANES-1:0][BYTE_W-1:0] part_q;
   logic [LANES-1:0][BYTE_W-1:0] part_d;
   logic [LIDX_W-1:0]            idx_q;
   logic                         emit;
   logic [WORD_W-1:0]            word_q;
   logic                         wr_q;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_comb begin
         if (take && (idx_q == LIDX_W'(l)))
            part_d[l] = in_byte;
         else if (take && close && (idx_q < LIDX_W'(l)))
            part_d[l] = DUMMY;
         else
            part_d[l] = part_q[l];
      end
   end

   assign emit = take && (close || (idx_q == LIDX_W'(LANES - 1)));

   always_ff @(posedge clk) begin
      if (rst) begin
         part_q <= '0;
         idx_q  <= '0;
         word_q <= '0;
         wr_q   <= 1'b0;
      end else begin
         wr_q <= emit;
         if (emit) begin
            word_q <= part_d;
            part_q <= '0;
            idx_q  <= '0;
         end else begin
            part_q <= part_d;
            if (take) idx_q <= idx_q + LIDX_W'(1);
         end
      end
   end

   assign word_out = word_q;
   assign word_wr  = wr_q;
   assign lane_idx = idx_q;

endmodule

// File: rtl/pkt_word_packer.sv
module pkt_word_packer #(
   parameter int                BYTE_W    = 8,
   parameter int                LANES     = 4,
   parameter int                CRC_BYTES = 2,
   parameter int                LONG_BIT  = 3,
   parameter logic [BYTE_W-1:0] DUMMY     = '0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_valid,
   input  logic [BYTE_W-1:0]       in_byte,
   output logic [BYTE_W*LANES-1:0] word_out,
   output logic                    word_wr
);
   localparam int LIDX_W = $clog2(LANES);

   if (LANES != 4) begin : g_bad_lanes
      $error("pkt_word_packer: header plus ECC must fill one word, LANES must be 4");
   end
   if (CRC_BYTES < 1) begin : g_bad_crc
      $error("pkt_word_packer: CRC_BYTES must be at least 1");
   end
   if (LONG_BIT >= BYTE_W) begin : g_bad_bit
      $error("pkt_word_packer: LONG_BIT must lie inside a byte");
   end

   pkw_pkg::pkw_state_e st_w;
   logic                take_w;
   logic                close_w;
   logic                hfirst_w;
   logic [LIDX_W-1:0]   lane_w;

   pkw_pkt_fsm #(
      .BYTE_W   (BYTE_W),
      .HDR_BYTES(LANES),
      .CRC_BYTES(CRC_BYTES),
      .LONG_BIT (LONG_BIT)
   ) fsm_i (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .take     (take_w),
      .close    (close_w),
      .hdr_first(hfirst_w),
      .state    (st_w)
   );

   pkw_lane_asm #(
      .BYTE_W(BYTE_W),
      .LANES (LANES),
      .DUMMY (DUMMY)
   ) asm_i (
      .clk     (clk),
      .rst     (rst),
      .in_byte (in_byte),
      .take    (take_w),
      .close   (close_w),
      .word_out(word_out),
      .word_wr (word_wr),
      .lane_idx(lane_w)
   );

endmodule

// File: rtl/pkw_checker.sv
module pkw_checker
   import pkw_pkg::*;
#(
   parameter int                BYTE_W = 8,
   parameter int                LANES  = 4,
   parameter logic [BYTE_W-1:0] DUMMY  = '0
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_valid,
   input logic [BYTE_W-1:0]        in_byte,
   input logic                     word_wr,
   input logic [BYTE_W*LANES-1:0]  word_out,
   input pkw_state_e               state,
   input logic                     take,
   input logic                     close,
   input logic                     hdr_first,
   input logic [$clog2(LANES)-1:0] lane_idx
);
   localparam int LIDX_W = $clog2(LANES);
   localparam int WORD_W = BYTE_W * LANES;

   // R1: a byte taken in the top lane completes the word in that lane
   p_top_lane_r1: assert property (@(posedge clk) disable iff (rst)
      (take && lane_idx == LIDX_W'(LANES - 1)) |=>
         (word_wr && word_out[WORD_W-1 -: BYTE_W] == $past(in_byte)));

   // R2: a packet's first byte always meets an empty word
   p_pkt_lane0_r2: assert property (@(posedge clk) disable iff (rst)
      hdr_first |-> (lane_idx == '0));

   // R4: a payload ending in lane 1 is padded in lanes 2 and up
   p_pad_fill_r4: assert property (@(posedge clk) disable iff (rst)
      (take && close && lane_idx == LIDX_W'(1)) |=>
         (word_wr && word_out[WORD_W-1:2*BYTE_W] == {(LANES-2){DUMMY}}));

   // R5: bytes consumed in the checksum phase never cause a write
   p_crc_drop_r5: assert property (@(posedge clk) disable iff (rst)
      (state == ST_CRC && in_valid) |=> !word_wr);

   // R6: no write without a valid byte one cycle earlier
   p_wr_needs_valid_r6: assert property (@(posedge clk) disable iff (rst)
      word_wr |-> $past(in_valid));

   // R7: reset silences the write strobe
   p_reset_quiet_r7: assert property (@(posedge clk)
      rst |=> !word_wr);

endmodule

bind pkt_word_packer pkw_checker #(
   .BYTE_W(BYTE_W),
   .LANES (LANES),
   .DUMMY (DUMMY)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_byte  (in_byte),
   .word_wr  (word_wr),
   .word_out (word_out),
   .state    (st_w),
   .take     (take_w),
   .close    (close_w),
   .hdr_first(hfirst_w),
   .lane_idx (lane_w)
);

// File: tb/pkt_word_packer_tb.sv
module pkt_word_packer_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic [31:0] word_out;
   logic        word_wr;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   bit          pend = 0;
   logic [31:0] pend_word = '0;
   string       pend_tag = "R7";

   logic [31:0] acc = '0;
   int          lane = 0;
   int          seq = 0;

   always #2 clk = ~clk;

   pkt_word_packer dut_i (
      .clk     (clk),
      .rst     (rst),
      .in_valid(in_valid),
      .in_byte (in_byte),
      .word_out(word_out),
      .word_wr (word_wr)
   );

   task automatic observe();
      checks++;
      if (word_wr !== pend) begin
         errors++;
         $display("FAIL %s (R8 strobe): word_wr=%0b expected %0b", pend_tag, word_wr, pend);
      end else if (pend) begin
         checks++;
         if (word_out !== pend_word) begin
            errors++;
            $display("FAIL %s: word_out=%08h expected %08h", pend_tag, word_out, pend_word);
         end
      end
   endtask

   task automatic drive(input bit v, input logic [7:0] b, input bit comp,
                        input logic [31:0] w, input string tag);
      @(negedge clk);
      observe();
      in_valid  = v;
      in_byte   = b;
      pend      = comp;
      pend_word = w;
      pend_tag  = tag;
   endtask

   task automatic push(input logic [7:0] b, input bit last, input bit gaps, input string tag);
      bit          comp;
      logic [31:0] w;
      seq++;
      if (gaps && (seq % 3 == 1)) drive(1'b0, 8'hEE, 1'b0, '0, "R6");
      acc[lane*8 +: 8] = b;
      comp = 1'b0;
      w = '0;
      if (lane == 3 || last) begin
         for (int k = lane + 1; k < 4; k++) acc[k*8 +: 8] = 8'h00;
         comp = 1'b1;
         w = acc;
         acc = '0;
         lane = 0;
      end else begin
         lane++;
      end
      drive(1'b1, b, comp, w, tag);
   endtask

   task automatic send_pkt(input logic [7:0] dt, input int len, input bit gaps);
      logic [15:0] l16;
      l16 = 16'(len);
      push(dt, 1'b0, gaps, "R2");
      push(l16[7:0], 1'b0, gaps, "R3");
      push(l16[15:8], 1'b0, gaps, "R3");
      push(dt ^ 8'h5A, 1'b1, gaps, "R3");
      if (dt[3]) begin
         for (int j = 0; j < len; j++)
            push(8'(j * 7 + len + 1), (j == len - 1), gaps,
                 ((len % 4) != 0 && j >= len - (len % 4)) ? "R4" : "R1");
         seq++;
         if (gaps && (seq % 3 == 1)) drive(1'b0, 8'hEE, 1'b0, '0, "R6");
         drive(1'b1, 8'hC3, 1'b0, '0, "R5");
         drive(1'b1, 8'h3C, 1'b0, '0, "R5");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R7: reset state
      checks++;
      if (word_wr !== 1'b0) begin
         errors++;
         $display("FAIL R7: word_wr=%0b expected 0 in reset", word_wr);
      end
      rst = 1'b0;

      // R3: short packets back to back
      send_pkt(8'h05, 16'h1234, 1'b0);
      send_pkt(8'h15, 16'h00AB, 1'b0);
      send_pkt(8'h21, 16'hFFFF, 1'b1);
      send_pkt(8'h37, 16'h0002, 1'b0);

      // R4, R5: length sweep, with and without gaps
      for (int g = 0; g < 2; g++)
         for (int n = 0; n < 14; n++)
            send_pkt((n % 2 == 0) ? 8'h39 : 8'h29, n, g[0]);

      // R4: high length byte in use
      send_pkt(8'h39, 256, 1'b0);
      send_pkt(8'h29, 301, 1'b1);
      send_pkt(8'h05, 16'h0000, 1'b0);

      // R7: reset mid-header, then a clean packet
      push(8'h39, 1'b0, 1'b0, "R7");
      push(8'h08, 1'b0, 1'b0, "R7");
      @(negedge clk);
      observe();
      rst = 1'b1; in_valid = 1'b1; in_byte = 8'h77; pend = 1'b0; pend_tag = "R7";
      @(negedge clk);
      observe();
      @(negedge clk);
      observe();
      rst = 1'b0; in_valid = 1'b0;
      acc = '0; lane = 0;
      send_pkt(8'h15, 16'h4321, 1'b0);
      send_pkt(8'h39, 5, 1'b0);

      drive(1'b0, 8'hEE, 1'b0, '0, "R6");
      drive(1'b0, 8'hEE, 1'b0, '0, "R6");
      drive(1'b0, 8'h00, 1'b0, '0, "R8");
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: finished=0 expected 1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule